// File: doc/BRIEF.md
# Transmit Driver Fail-Safe Gate

This block sits between the synchronized transmit data line of a CAN transceiver and the control input of its bus driver. It turns a low (dominant) transmit bit into a driver-dominant command only when the operating mode allows transmission and no protection fault is active. In every other case it holds the bus recessive.

It carries two latched protections of its own. The first is a dominant timeout. A counter accumulates the time the transmit line spends low and, past a programmable limit, latches a fault that releases the bus. The counter and the fault are cleared only by a qualified recessive interval, meaning the line has stayed high for a minimum number of consecutive cycles. The second is an overtemperature latch. It is set by the thermal flag and released only once the flag has dropped while the transmit line is high, so thermal drift near the threshold cannot make the driver oscillate. An externally detected receive-clamp fault also forces recessive, but it is not latched here. Each latched fault is reported on its own status output.

Top module: `tfg_gate`

## Requirements
- R1: `drv_dom_o` is 1 only in a cycle where `tx_en_i`=1, `txd_i`=0 (0 means dominant), `clamp_i`=0, `ovt_i`=0 and neither fault latch is set. Otherwise it is 0.
- R2: The dominant timer counts every cycle with `txd_i`=0, whatever the mode. After TO_CYCLES low cycles, counted from the last clear, `flt_timeout_o` reads 1 from the next cycle on and the driver goes recessive.
- R3: Once set, the timeout fault stays set until `txd_i` has been 1 for REC_CYCLES consecutive cycles. It reads 0 in the cycle after the last of these. A fresh low then drives dominant at once.
- R4: A high interval shorter than REC_CYCLES neither clears the fault nor resets the low-time count, so low time accumulates across short highs.
- R5: `ovt_i`=1 forces `drv_dom_o` to 0 in the same cycle, and `flt_overtemp_o` reads 1 from the next cycle on.
- R6: The overtemperature latch clears only at a clock edge where `ovt_i`=0 and `txd_i`=1. While `txd_i` stays 0 it holds, even after `ovt_i` has dropped.
- R7: `clamp_i`=1 forces `drv_dom_o` to 0 in the same cycle. It is not latched, and it does not touch either fault.
- R8: While `rst` is 1 at a clock edge, both faults and both counters clear. After reset, `drv_dom_o`, `flt_timeout_o` and `flt_overtemp_o` read 0 until an input calls for otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| txd_i | input | 1 | Synchronized transmit data, 0 = dominant |
| tx_en_i | input | 1 | Mode permits transmission |
| clamp_i | input | 1 | Receive recessive-clamp fault from the mode logic |
| ovt_i | input | 1 | Junction temperature above shutdown limit |
| drv_dom_o | output | 1 | Command to drive the bus dominant |
| flt_timeout_o | output | 1 | Dominant-timeout fault latched |
| flt_overtemp_o | output | 1 | Overtemperature fault latched |

## Verification
The in-RTL assertions check several properties on every cycle. A timeout fault can only rise after a low cycle and can only fall after a high cycle. It cannot drop while the line is low. The low-time count never passes its limit. The thermal latch follows the flag in the next cycle and releases only on a high, cool cycle. The driver is never dominant while a latch is set. Only the bench scenarios can show the exact timing. Those cover the cycle in which the timeout trips after accumulated low time, the exact length of the recessive interval that clears it, that short highs do not reset the count, and the order of release when the flag drops while the line is still low.

// File: rtl/tfg_pkg.sv
package tfg_pkg;

    typedef struct packed {
        logic timeout;
        logic overtemp;
    } tfg_flt_t;

    function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
        return (v >= lim) ? lim : v + 1;
    endfunction

endpackage

// File: rtl/tfg_dom_timer.sv
module tfg_dom_timer #(
    parameter int unsigned TO_CYCLES  = 2000,
    parameter int unsigned REC_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic txd_i,
    output logic flt_o
);
    localparam int unsigned LW = $clog2(TO_CYCLES + 1);
    localparam int unsigned HW = $clog2(REC_CYCLES + 1);

    logic [LW-1:0] lo_cnt, lo_nxt;
    logic [HW-1:0] hi_cnt, hi_nxt;
    logic          flt_q, flt_nxt;
    logic          run_done;

    always_comb begin
        hi_nxt   = txd_i ? HW'(tfg_pkg::sat_inc(32'(hi_cnt), REC_CYCLES)) : '0;
        run_done = txd_i && (hi_nxt == HW'(REC_CYCLES));
        if (run_done)
            lo_nxt = '0;
        else if (!txd_i)
            lo_nxt = LW'(tfg_pkg::sat_inc(32'(lo_cnt), TO_CYCLES));
        else
            lo_nxt = lo_cnt;
        if (run_done)
            flt_nxt = 1'b0;
        else if (!txd_i && lo_cnt >= LW'(TO_CYCLES - 1))
            flt_nxt = 1'b1;
        else
            flt_nxt = flt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt <= '0;
            hi_cnt <= '0;
            flt_q  <= 1'b0;
        end else begin
            lo_cnt <= lo_nxt;
            hi_cnt <= hi_nxt;
            flt_q  <= flt_nxt;
        end
    end

    assign flt_o = flt_q;

    a_r2_set_after_low: assert property (@(posedge clk) disable iff (rst)
        $rose(flt_q) |-> $past(!txd_i));
    a_r3_hold_while_low: assert property (@(posedge clk) disable iff (rst)
        (flt_q && !txd_i) |=> flt_q);
    a_r3_clear_after_high: assert property (@(posedge clk) disable iff (rst)
        $fell(flt_q) |-> $past(txd_i));
    a_r4_count_bounded: assert property (@(posedge clk) disable iff (rst)
        lo_cnt <= LW'(TO_CYCLES));

endmodule

// File: rtl/tfg_ot_latch.sv
module tfg_ot_latch (
    input  logic clk,
    input  logic rst,
    input  logic txd_i,
    input  logic ovt_i,
    output logic flt_o
);
    logic ot_q;

    always_ff @(posedge clk) begin
        if (rst)
            ot_q <= 1'b0;
        else if (ovt_i)
            ot_q <= 1'b1;
        else if (txd_i)
            ot_q <= 1'b0;
    end

    assign flt_o = ot_q;

    a_r5_latch_when_hot: assert property (@(posedge clk) disable iff (rst)
        ovt_i |=> ot_q);
    a_r6_release_high_cool: assert property (@(posedge clk) disable iff (rst)
        $fell(ot_q) |-> $past(txd_i && !ovt_i));
    a_r6_hold_while_low: assert property (@(posedge clk) disable iff (rst)
        (ot_q && !txd_i) |=> ot_q);

endmodule

// File: rtl/tfg_gate.sv
module tfg_gate #(
    parameter int unsigned TO_CYCLES  = 2000,
    parameter int unsigned REC_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic txd_i,
    input  logic tx_en_i,
    input  logic clamp_i,
    input  logic ovt_i,
    output logic drv_dom_o,
    output logic flt_timeout_o,
    output logic flt_overtemp_o
);
    tfg_pkg::tfg_flt_t flt;
    logic              permit;

    tfg_dom_timer #(.TO_CYCLES(TO_CYCLES), .REC_CYCLES(REC_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .txd_i (txd_i),
        .flt_o (flt.timeout)
    );

    tfg_ot_latch u_ot (
        .clk   (clk),
        .rst   (rst),
        .txd_i (txd_i),
        .ovt_i (ovt_i),
        .flt_o (flt.overtemp)
    );

    always_comb begin
        permit    = tx_en_i && !clamp_i && !ovt_i && (flt == '0);
        drv_dom_o = permit && !txd_i;
    end

    assign flt_timeout_o  = flt.timeout;
    assign flt_overtemp_o = flt.overtemp;

    a_r1_no_dom_under_fault: assert property (@(posedge clk) disable iff (rst)
        drv_dom_o |-> !(flt.timeout || flt.overtemp));
    a_r8_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (flt == '0));

endmodule

// File: tb/tb_tfg_gate.sv
module tb_tfg_gate;
    localparam int PERIOD = 10;
    localparam int TO  = 20;
    localparam int REC = 4;

    logic clk = 0, rst = 1;
    logic txd = 1, en = 0, cl = 0, ov = 0;
    logic drv, fto, fot;

    int checks = 0, fails = 0;
    int lo = 0, hi = 0;
    bit to_m = 0, ot_m = 0, armed = 0, done = 0;
    string req = "R8";

    tfg_gate #(.TO_CYCLES(TO), .REC_CYCLES(REC)) dut (
        .clk(clk), .rst(rst), .txd_i(txd), .tx_en_i(en), .clamp_i(cl), .ovt_i(ov),
        .drv_dom_o(drv), .flt_timeout_o(fto), .flt_overtemp_o(fot));

    always #(PERIOD/2) clk = ~clk;

    // behavioural reference model, advanced on each rising edge
    always @(posedge clk) begin
        armed <= 1;
        if (rst) begin
            lo = 0; hi = 0; to_m = 0; ot_m = 0;
        end else begin
            if (!txd) begin
                hi = 0;
                lo = lo + 1;
                if (lo >= TO) to_m = 1;
            end else begin
                hi = hi + 1;
                if (hi >= REC) begin lo = 0; to_m = 0; end
            end
            if (ov) ot_m = 1;
            else if (txd) ot_m = 0;
        end
    end

    task automatic chk(input string r, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", r, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !done) begin
            chk(req, "drv", drv, en && !txd && !cl && !ov && !to_m && !ot_m);
            chk(req, "timeout", fto, to_m);
            chk(req, "overtemp", fot, ot_m);
        end
    end

    task automatic run(input logic t, input logic e, input logic c, input logic o, input int n);
        txd = t; en = e; cl = c; ov = o;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(PERIOD * 20000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        #4;
        // R8 reset state
        chk("R8", "drv after reset", drv, 1'b0);
        chk("R8", "timeout after reset", fto, 1'b0);
        chk("R8", "overtemp after reset", fot, 1'b0);
        @(posedge clk); #1;

        req = "R1";
        for (int i = 0; i < 6; i++) begin
            run(0, 1, 0, 0, 3 + i);
            run(1, 1, 0, 0, 5);
        end
        run(0, 0, 0, 0, 3);          // no enable: recessive
        run(1, 1, 0, 0, 5);

        req = "R7";
        run(0, 1, 0, 0, 2);
        run(0, 1, 1, 0, 2);
        #3; chk("R7", "drv under clamp", drv, 1'b0);
        @(posedge clk); #1;
        run(0, 1, 0, 0, 2);
        #3; chk("R7", "drv after clamp drop", drv, 1'b1);
        run(1, 1, 0, 0, 5);

        req = "R2";
        run(0, 1, 0, 0, TO - 1);
        #3; chk("R2", "drv on last allowed cycle", drv, 1'b1);
        @(posedge clk); #1;
        #3; chk("R2", "timeout set", fto, 1'b1);
        chk("R2", "drv released", drv, 1'b0);
        run(0, 1, 0, 0, 10);

        req = "R3";
        run(1, 1, 0, 0, REC - 1);
        run(0, 1, 0, 0, 3);
        #3; chk("R3", "fault held after short high", fto, 1'b1);
        run(1, 1, 0, 0, REC);
        #3; chk("R3", "fault cleared", fto, 1'b0);
        run(0, 1, 0, 0, 1);
        run(1, 1, 0, 0, REC);

        req = "R4";
        run(0, 1, 0, 0, TO - 5);
        run(1, 1, 0, 0, REC - 1);
        run(0, 1, 0, 0, 5);
        #3; chk("R4", "accumulated low trips", fto, 1'b1);
        run(1, 1, 0, 0, REC + 2);

        req = "R5";
        run(0, 1, 0, 1, 1);
        #3; chk("R5", "drv off while hot", drv, 1'b0);
        chk("R5", "latch set", fot, 1'b1);
        req = "R6";
        run(0, 1, 0, 0, 4);
        #3; chk("R6", "latch held while low", fot, 1'b1);
        chk("R6", "drv off while latched", drv, 1'b0);
        run(1, 1, 0, 0, 1);
        #3; chk("R6", "latch released", fot, 1'b0);
        run(0, 1, 0, 0, 2);
        run(1, 1, 0, 1, 3);
        run(1, 1, 0, 0, 3);
        run(0, 0, 0, 1, 2);
        run(1, 0, 0, 0, REC + 2);

        req = "R8";
        run(0, 1, 0, 1, TO + 2);
        rst = 1;
        run(1, 1, 0, 0, 2);
        rst = 0;
        #3; chk("R8", "timeout reset", fto, 1'b0);
        chk("R8", "overtemp reset", fot, 1'b0);
        run(1, 1, 0, 0, 3);
        finish_run();
    end
endmodule